// File: doc/BRIEF.md
# Bit-Serial Fixed-Coefficient Multiplier

This block multiplies a serial two's complement data word by a constant coefficient. The coefficient is fixed when the block is built and written in canonic signed digit form: every digit is -1, 0 or +1, and no two neighbouring digits are both non-zero. The data word arrives one bit per clock, least significant bit first. The block returns the low `N` bits of the product one bit per clock, in the same order.

Inside is a row of `M` cells, one for each coefficient digit. A cell with a zero digit holds no adder and only moves the running partial sum one place down the row. A cell with a non-zero digit adds the data bit to that sum with a full adder. A -1 digit adds the inverted data bit. On the word's last bit a strobe inverts the data once more, which gives the sign bit its negative weight. The constant that both inversions leave behind is computed when the block is built. It enters through the carry flops, which are preset on the first bit, through the pass-through path of the zero-digit cells, and through a bit stream fed into the top of the row.

The higher product bits are left in carry-save form inside the row and are never read out. A new word may start at any cycle after the previous one, and a new start cancels the word in progress. Each word must carry the last-bit strobe on its `N`-th bit.

Top module: `csd_serial_mult`

## Requirements
- R1: After reset `prod_valid` and `prod_bit` are both 0.
- R2: If `word_start` is high in cycle t, then `prod_valid` is high in cycles t+1 through t+N. In cycle t+1+i, `prod_bit` is bit i of the signed product of the coefficient and the data word, where data bit i was driven in cycle t+i.
- R3: A coefficient with -1 digits (the default is +16 -4 +1 = 13) gives the correct product for zero, positive and negative data words.
- R4: The sign boundary values -2^(N-1), -1 and 2^(N-1)-1 give the correct low product bits, with `word_last` high on the word's N-th bit.
- R5: `word_start` raised before the current word's last bit drops that word. The new word's bits follow R2 from the new start.
- R6: Outside an active window `prod_valid` and `prod_bit` stay 0, whatever `din` carries. A later word's result is unaffected by that data.
- R7: A word whose `word_start` comes in the cycle right after the previous word's last bit is multiplied correctly, with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial data bit, LSB first |
| word_start | input | 1 | High with bit 0 of a word |
| word_last | input | 1 | High with bit N-1 of a word |
| prod_bit | output | 1 | Serial product bit, LSB first |
| prod_valid | output | 1 | High while `prod_bit` carries a product bit |

## Verification
A bad preset constant or a wrong carry in one cell moves a weight 2^k of the sum. That error appears on `prod_bit` exactly k cycles into the word, or at the first bit where the carry travels. So a bit-by-bit comparison against a signed multiply finds it within the word where it first matters. A wrong inversion on the last bit affects only bit N-1 and above, which is why the sign boundary words are driven on purpose. State left over from a previous word would corrupt bit 0 of the next one, so words are also run back to back and after a cancelled word.

// File: rtl/csd_serial_mult.sv
module csd_serial_mult #(
  parameter int N = 8,
  parameter int M = 6,
  parameter logic [M-1:0] DIG_POS = 6'b010001,
  parameter logic [M-1:0] DIG_NEG = 6'b000100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic word_start,
  input  logic word_last,
  output logic prod_bit,
  output logic prod_valid
);
  localparam int CW  = $clog2(N + 1);
  localparam int SQW = (M > 1) ? M - 1 : 1;
  localparam logic [CW-1:0] NCNT = CW'(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  function automatic logic [N-1:0] corr_f();
    logic [N-1:0] one, acc;
    one = {{(N-1){1'b0}}, 1'b1};
    acc = '0;
    for (int k = 0; k < M; k++)
      if (DIG_NEG[k]) acc = acc + (one << k);
    if (DIG_POS[0] | DIG_NEG[0]) acc = acc - {1'b1, {(N-1){1'b0}}};
    return acc;
  endfunction

  localparam logic [N-1:0] CORR = corr_f();

  function automatic logic corr_bit(int idx);
    return (idx >= 0 && idx < N) ? CORR[idx] : 1'b0;
  endfunction

  logic [CW-1:0] cnt_q, t_eff;
  logic          active, top_bit;
  logic [M-1:0]  sum_c;
  logic [SQW:1]  s_q;

  assign t_eff   = word_start ? '0 : cnt_q;
  assign active  = t_eff < NCNT;
  assign top_bit = corr_bit(M - 1 + int'(t_eff));

  for (genvar k = 0; k < M; k++) begin : g_cell
    localparam bit NZ  = DIG_POS[k] | DIG_NEG[k];
    localparam bit PRE = corr_bit(k);
    logic a_chain;
    if (k == M - 1) begin : g_top
      assign a_chain = top_bit;
    end else begin : g_mid
      assign a_chain = s_q[k+1];
    end
    if (NZ) begin : g_add
      logic c_r, c_nx, y, a_eff, c_eff;
      assign y     = din ^ DIG_NEG[k] ^ word_last;
      assign a_eff = word_start ? 1'b0 : a_chain;
      assign c_eff = word_start ? PRE : c_r;
      assign {c_nx, sum_c[k]} = {1'b0, a_eff} + {1'b0, y} + {1'b0, c_eff};
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) c_r <= 1'b0;
        else        c_r <= c_nx;
    end else begin : g_pass
      assign sum_c[k] = word_start ? PRE : a_chain;
    end
    if (k > 0) begin : g_sreg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) s_q[k] <= 1'b0;
        else        s_q[k] <= sum_c[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= NCNT;
      prod_bit   <= 1'b0;
      prod_valid <= 1'b0;
    end else begin
      if (active) cnt_q <= t_eff + CW'(1);
      prod_bit   <= active & sum_c[0];
      prod_valid <= active;
    end
  end

  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |=> prod_valid);
  p_rise_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prod_valid) |-> $past(word_start));
  p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!prod_valid && !word_start) |=> !prod_valid);
  p_quiet_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_valid |-> !prod_bit);
  p_last_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_last |-> (t_eff == LAST));
endmodule

// File: tb/csd_serial_mult_tb.sv
module csd_serial_mult_tb_top;
  localparam int N = 8;
  localparam int M = 6;
  localparam logic [M-1:0] DPOS = 6'b010001;
  localparam logic [M-1:0] DNEG = 6'b000100;
  localparam time PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic din = 1'b0, word_start = 1'b0, word_last = 1'b0;
  logic prod_bit, prod_valid;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] expq[$];
  longint coef;

  always #(PERIOD/2) clk = ~clk;

  csd_serial_mult #(.N(N), .M(M), .DIG_POS(DPOS), .DIG_NEG(DNEG)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .word_start(word_start),
    .word_last(word_last), .prod_bit(prod_bit), .prod_valid(prod_valid));

  task automatic check_out(string tag);
    logic [1:0] e;
    e = (expq.size() > 0) ? expq.pop_front() : 2'b00;
    checks++;
    if (prod_valid !== e[1] || prod_bit !== e[0]) begin
      errors++;
      $display("FAIL %s: valid/bit got %b%b expected %b%b at %0t",
               tag, prod_valid, prod_bit, e[1], e[0], $time);
    end
  endtask

  task automatic step(string tag, logic x, logic s, logic l, logic ev, logic eb);
    @(negedge clk);
    check_out(tag);
    din = x; word_start = s; word_last = l;
    expq.push_back({ev, ev & eb});
  endtask

  task automatic send(string tag, logic [N-1:0] w, int len);
    longint p;
    p = coef * longint'($signed(w));
    for (int i = 0; i < len; i++)
      step(tag, w[i], i == 0, i == N - 1, 1'b1, p[i]);
  endtask

  task automatic idle(string tag, int c);
    for (int i = 0; i < c; i++) step(tag, 1'($urandom), 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    coef = 0;
    for (int k = 0; k < M; k++)
      coef += (DPOS[k] ? 64'sd1 : DNEG[k] ? -64'sd1 : 64'sd0) <<< k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_out("R1");
    expq.push_back(2'b00);
    // R3 / R2: assorted words with idle gaps between them
    send("R3", 8'h00, N); idle("R6", N);
    send("R3", 8'h01, N); idle("R6", N);
    send("R2", 8'h5A, N); idle("R6", N);
    send("R3", 8'hA5, N); idle("R6", N);
    // R4: sign boundary words
    send("R4", 8'h80, N); idle("R6", N);
    send("R4", 8'hFF, N); idle("R6", N);
    send("R4", 8'h7F, N); idle("R6", 3);
    // R7: back-to-back words
    send("R7", 8'h80, N);
    send("R7", 8'h7F, N);
    send("R7", 8'hC3, N);
    idle("R6", 2);
    // R5: cancelled word followed by a fresh start
    send("R5", 8'hFF, 3);
    send("R5", 8'h96, N);
    idle("R6", 5);
    for (int r = 0; r < 40; r++) begin
      send("R2", N'($urandom), N);
      idle("R6", r % 3);
    end
    idle("R6", N + 2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule